// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Translator

This block bridges a big-endian processor bus to a little-endian ISA-style I/O bus. A processor access is started with a one-cycle `cpu_start` strobe carrying address, direction, size (byte, halfword or word) and write data. When the address falls inside the 8 MB I/O window based at 0x80000000, the block claims it. It then forms an I/O port number according to a map-mode input and reverses the byte lanes of multi-byte data in both directions. It issues exactly one downstream request and waits for the device to answer before it completes the access.

A second, 4-byte region at 0xBFFFFFF0 serves interrupt acknowledge. A read at the first byte of that region runs an acknowledge cycle with the interrupt controller and returns the vector, lane-swapped like any other read. The other offsets in that region, and every write there, complete locally without any downstream traffic. Addresses outside both regions are not claimed.

Only one access is in flight at a time. A start strobe that arrives while an access is outstanding is ignored.

Top module: `cpu_isa_bridge`

## Requirements
- R1: In the cycle of `cpu_start`, `cpu_hit` is high exactly when the bridge is idle and the address lies in 0x80000000..0x807FFFFF or 0xBFFFFFF0..0xBFFFFFF3. For any other address `cpu_hit` stays low, and no downstream request or completion follows.
- R2: With `map_mode`=0 (contiguous), `io_port` equals address bits 15:0, zero-extended to 20 bits.
- R3: With `map_mode`=1 (scattered), `io_port[4:0]` equals address bits 4:0 and `io_port[19:5]` equals address bits 26:12. Address bits 11:5 are dropped.
- R4: Size encoding is 0=byte, 1=halfword, 2=word, with data right-justified on both buses. For writes, a byte passes `cpu_wdata` unchanged. A halfword drives `{16'h0, d[7:0], d[15:8]}`. A word drives the four bytes in reverse order.
- R5: For window reads, `cpu_rdata` is `io_rdata` transformed by the same per-size lane rule as in R4.
- R6: A claimed window access raises `io_req` in the cycle after the start. `io_req` then stays high, with `io_port`, `io_wdata` and `io_write` stable, until `io_ready` is seen. `cpu_done` pulses for one cycle in the cycle after `io_ready`.
- R7: `map_mode` is sampled in the start cycle. A change while the access is outstanding does not alter `io_port`.
- R8: A read at 0xBFFFFFF0 raises `ack_req` (never `io_req`) until `ack_ready`. `cpu_done` follows one cycle later, with `cpu_rdata` equal to the zero-extended `ack_vector` lane-swapped per R4.
- R9: A write anywhere in 0xBFFFFFF0..0xBFFFFFF3, or a read at 0xBFFFFFF1..0xBFFFFFF3, makes no downstream request. It completes with `cpu_done` in the cycle after the start, and a read returns 0.
- R10: A `cpu_start` while an access is outstanding is ignored. `cpu_hit` stays low, and the outstanding request's port and data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 = contiguous port map, 1 = scattered port map |
| cpu_start | input | 1 | One-cycle access start strobe |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Processor physical address |
| cpu_wdata | input | 32 | Write data, right-justified, big-endian |
| cpu_hit | output | 1 | Access claimed (valid in the start cycle) |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| io_req | output | 1 | Downstream I/O request, held until ready |
| io_write | output | 1 | Downstream direction |
| io_size | output | 2 | Downstream access size |
| io_port | output | 20 | Translated I/O port number |
| io_wdata | output | 32 | Lane-swapped write data |
| io_ready | input | 1 | Device response strobe |
| io_rdata | input | 32 | Device read data, little-endian |
| ack_req | output | 1 | Interrupt acknowledge request, held until ready |
| ack_ready | input | 1 | Interrupt controller response strobe |
| ack_vector | input | 8 | Interrupt vector from the controller |

## Verification
The bound assertions watch the handshake on every cycle. They check that the I/O and acknowledge requests are never high together, that a pending I/O request keeps its port and data steady, that every response leads to exactly one completion pulse, and that unclaimed or overlapping starts never raise the hit flag. The address arithmetic of both map modes and the lane order for each size are data-dependent, so the bench's vector walk over chosen addresses and payloads is what shows them correct. The same holds for the sampling of the map mode at the start, the locally completed acknowledge-region offsets and the swapped interrupt vector, which only directed scenarios expose.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

    localparam int unsigned BUS_W    = 32;
    localparam int unsigned LANES    = BUS_W / 8;
    localparam int unsigned PORT_W   = 20;
    localparam int unsigned WIN_BITS = 23;                 // 8 MB window
    localparam logic [31:0] WIN_BASE = 32'h8000_0000;
    localparam logic [31:0] ACK_BASE = 32'hBFFF_FFF0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IO_WAIT,
        ST_ACK_WAIT,
        ST_DONE
    } bridge_state_e;

    typedef struct packed {
        logic claim;      // address belongs to this block
        logic to_io;      // forward to the I/O bus
        logic to_ack;     // run an interrupt acknowledge cycle
    } decode_t;

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
    import isa_bridge_pkg::*;
(
    input  logic [31:0]        addr,
    input  logic               write,
    input  logic               map_mode,
    output decode_t            dec,
    output logic [PORT_W-1:0]  port
);
    logic in_win;
    logic in_ack;

    always_comb begin
        in_win = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
        in_ack = (addr[31:2] == ACK_BASE[31:2]);

        dec.claim  = in_win | in_ack;
        dec.to_io  = in_win;
        dec.to_ack = in_ack & ~write & (addr[1:0] == ACK_BASE[1:0]);

        if (map_mode) begin
            // scattered map: one 32-port slice per 4 KB page
            port = {addr[26:12], addr[4:0]};
        end else begin
            port = {{(PORT_W-16){1'b0}}, addr[15:0]};
        end
    end
endmodule

// File: rtl/isa_lane_swap.sv
module isa_lane_swap
    import isa_bridge_pkg::*;
(
    input  xfer_size_e         size,
    input  logic [BUS_W-1:0]   din,
    output logic [BUS_W-1:0]   dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_HALF: dout[8*i +: 8] = (i < 2) ? din[8*(1-i) +: 8] : 8'h00;
                SZ_WORD: dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
                default: dout[8*i +: 8] = din[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/cpu_isa_bridge.sv
module cpu_isa_bridge
    import isa_bridge_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               map_mode,
    input  logic               cpu_start,
    input  logic               cpu_write,
    input  logic [1:0]         cpu_size,
    input  logic [31:0]        cpu_addr,
    input  logic [31:0]        cpu_wdata,
    output logic               cpu_hit,
    output logic               cpu_done,
    output logic [31:0]        cpu_rdata,
    output logic               io_req,
    output logic               io_write,
    output logic [1:0]         io_size,
    output logic [19:0]        io_port,
    output logic [31:0]        io_wdata,
    input  logic               io_ready,
    input  logic [31:0]        io_rdata,
    output logic               ack_req,
    input  logic               ack_ready,
    input  logic [VEC_W-1:0]   ack_vector
);
    bridge_state_e     state;
    decode_t           dec;
    logic [PORT_W-1:0] port_calc;
    logic [BUS_W-1:0]  wdata_sw;
    logic [BUS_W-1:0]  rsrc;
    logic [BUS_W-1:0]  rdata_sw;
    xfer_size_e        size_q;
    logic [PORT_W-1:0] port_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [BUS_W-1:0]  rdata_q;
    logic              wr_q;
    logic              accept;

    isa_addr_decode u_decode (
        .addr     (cpu_addr),
        .write    (cpu_write),
        .map_mode (map_mode),
        .dec      (dec),
        .port     (port_calc)
    );

    isa_lane_swap u_wswap (
        .size (xfer_size_e'(cpu_size)),
        .din  (cpu_wdata),
        .dout (wdata_sw)
    );

    assign rsrc = (state == ST_ACK_WAIT)
                ? {{(BUS_W-VEC_W){1'b0}}, ack_vector}
                : io_rdata;

    isa_lane_swap u_rswap (
        .size (size_q),
        .din  (rsrc),
        .dout (rdata_sw)
    );

    assign accept = (state == ST_IDLE) && cpu_start && dec.claim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            size_q  <= SZ_BYTE;
            port_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    size_q <= xfer_size_e'(cpu_size);
                    if (dec.to_io) begin
                        port_q  <= port_calc;
                        wdata_q <= wdata_sw;
                        wr_q    <= cpu_write;
                        state   <= ST_IO_WAIT;
                    end else if (dec.to_ack) begin
                        state   <= ST_ACK_WAIT;
                    end else begin
                        rdata_q <= '0;
                        state   <= ST_DONE;
                    end
                end
                ST_IO_WAIT: if (io_ready) begin
                    rdata_q <= rdata_sw;
                    state   <= ST_DONE;
                end
                ST_ACK_WAIT: if (ack_ready) begin
                    rdata_q <= rdata_sw;
                    state   <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_hit   = accept;
    assign cpu_done  = (state == ST_DONE);
    assign cpu_rdata = rdata_q;
    assign io_req    = (state == ST_IO_WAIT);
    assign io_write  = wr_q;
    assign io_size   = size_q;
    assign io_port   = port_q;
    assign io_wdata  = wdata_q;
    assign ack_req   = (state == ST_ACK_WAIT);
endmodule

// File: rtl/cpu_isa_bridge_chk.sv
module cpu_isa_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_start,
    input logic [31:0] cpu_addr,
    input logic        cpu_hit,
    input logic        cpu_done,
    input logic        io_req,
    input logic        io_ready,
    input logic        io_write,
    input logic [19:0] io_port,
    input logic [31:0] io_wdata,
    input logic        ack_req,
    input logic        ack_ready
);
    assert_miss_no_hit_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_start && cpu_addr[31:23] != 9'h100 && cpu_addr[31:2] != 30'h2FFF_FFFC)
        |-> !cpu_hit);

    assert_hold_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (io_req && !io_ready) |=>
        (io_req && $stable(io_port) && $stable(io_wdata) && $stable(io_write)));

    assert_io_done_R6: assert property (@(posedge clk) disable iff (rst)
        (io_req && io_ready) |=> (cpu_done && !io_req));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    assert_ack_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(io_req && ack_req));

    assert_ack_done_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_req && ack_ready) |=> (cpu_done && !ack_req));

    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (io_req || ack_req || cpu_done) |-> !cpu_hit);

    assert_hit_progress_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |=> (io_req || ack_req || cpu_done));
endmodule

bind cpu_isa_bridge cpu_isa_bridge_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_start (cpu_start),
    .cpu_addr  (cpu_addr),
    .cpu_hit   (cpu_hit),
    .cpu_done  (cpu_done),
    .io_req    (io_req),
    .io_ready  (io_ready),
    .io_write  (io_write),
    .io_port   (io_port),
    .io_wdata  (io_wdata),
    .ack_req   (ack_req),
    .ack_ready (ack_ready)
);

// File: tb/test_cpu_isa_bridge.sv
module test_cpu_isa_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_mode = 1'b0;
    logic        cpu_start = 1'b0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_hit, cpu_done;
    logic [31:0] cpu_rdata;
    logic        io_req, io_write;
    logic [1:0]  io_size;
    logic [19:0] io_port;
    logic [31:0] io_wdata;
    logic        io_ready = 1'b0;
    logic [31:0] io_rdata = '0;
    logic        ack_req;
    logic        ack_ready = 1'b0;
    logic [7:0]  ack_vector = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cpu_isa_bridge i_cpu_isa_bridge (.*);

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic        mp;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rsp;
        logic [19:0] port;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 1'b0, 32'h8000_03F8, 32'h0,         32'h0000_00A5, 20'h003F8, 32'h0000_00A5},
        '{1'b1, 2'd1, 1'b0, 32'h8000_1234, 32'h0000_BEEF, 32'h0,         20'h01234, 32'h0000_EFBE},
        '{1'b1, 2'd2, 1'b0, 32'h8000_FFFC, 32'h1122_3344, 32'h0,         20'h0FFFC, 32'h4433_2211},
        '{1'b0, 2'd2, 1'b1, 32'h807F_F01F, 32'h0,         32'hA1B2_C3D4, 20'h0FFFF, 32'hD4C3_B2A1},
        '{1'b0, 2'd1, 1'b1, 32'h8012_3456, 32'h0,         32'h0000_5AA5, 20'h02476, 32'h0000_A55A},
        '{1'b1, 2'd0, 1'b1, 32'h8040_0003, 32'h0000_007E, 32'h0,         20'h08003, 32'h0000_007E},
        '{1'b1, 2'd2, 1'b1, 32'h8000_0020, 32'hCAFE_F00D, 32'h0,         20'h00000, 32'h0DF0_FECA},
        '{1'b0, 2'd0, 1'b0, 32'h807A_BCDE, 32'h0,         32'h1234_5678, 20'h0BCDE, 32'h1234_5678}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_access(
        input  logic        w,
        input  logic [1:0]  sz,
        input  logic        mp,
        input  logic [31:0] a,
        input  logic [31:0] wd,
        input  logic [31:0] rsp,
        output logic        h,
        output logic [19:0] prt,
        output logic [31:0] iwd,
        output logic [31:0] rd,
        output int          nio,
        output int          nack,
        output int          ndone
    );
        nio = 0; nack = 0; ndone = 0; prt = '0; iwd = '0; rd = '0;
        @(negedge clk);
        cpu_start = 1'b1; cpu_write = w; cpu_size = sz; map_mode = mp;
        cpu_addr = a; cpu_wdata = wd;
        #1 h = cpu_hit;
        @(negedge clk);
        cpu_start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (io_req) begin
                nio++; prt = io_port; iwd = io_wdata;
                io_ready = 1'b1; io_rdata = rsp;
            end
            if (ack_req) begin
                nack++; ack_ready = 1'b1; ack_vector = rsp[7:0];
            end
            if (cpu_done) begin
                ndone++; rd = cpu_rdata;
            end
            @(negedge clk);
            io_ready = 1'b0; ack_ready = 1'b0;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%08h expected=%08h", cycles, 0);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic        h;
        logic [19:0] prt;
        logic [31:0] iwd, rd;
        int          nio, nack, ndone;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(!io_req && !ack_req && !cpu_done && !cpu_hit, "R6 reset idle",
              {28'h0, io_req, ack_req, cpu_done, cpu_hit}, 32'h0);
        check(cpu_rdata == 32'h0, "R6 reset rdata", cpu_rdata, 32'h0);

        // vector walk: R2/R3 port map, R4/R5 lane swapping, R6 handshake
        for (int v = 0; v < NVEC; v++) begin
            do_access(VECS[v].wr, VECS[v].sz, VECS[v].mp, VECS[v].addr,
                      VECS[v].wd, VECS[v].rsp, h, prt, iwd, rd, nio, nack, ndone);
            check(h, "R1 window hit", {31'h0, h}, 32'h1);
            check(nio == 1 && nack == 0, "R6 single io request", nio, 1);
            check(ndone == 1, "R6 single completion", ndone, 1);
            check(prt == VECS[v].port, VECS[v].mp ? "R3 scattered port" : "R2 contiguous port",
                  {12'h0, prt}, {12'h0, VECS[v].port});
            if (VECS[v].wr)
                check(iwd == VECS[v].exp, "R4 write lanes", iwd, VECS[v].exp);
            else
                check(rd == VECS[v].exp, "R5 read lanes", rd, VECS[v].exp);
        end

        // R1 misses: just above the window and just below it
        do_access(1'b0, 2'd2, 1'b0, 32'h8080_0000, 32'h0, 32'h0, h, prt, iwd, rd, nio, nack, ndone);
        check(!h && nio == 0 && nack == 0 && ndone == 0, "R1 miss above window",
              {28'h0, h, nio[0], nack[0], ndone[0]}, 32'h0);
        do_access(1'b1, 2'd0, 1'b1, 32'h7FFF_FFFF, 32'h55, 32'h0, h, prt, iwd, rd, nio, nack, ndone);
        check(!h && nio == 0 && nack == 0 && ndone == 0, "R1 miss below window",
              {28'h0, h, nio[0], nack[0], ndone[0]}, 32'h0);

        // R8 interrupt acknowledge reads at 0xBFFFFFF0, vector 0x21
        do_access(1'b0, 2'd0, 1'b0, 32'hBFFF_FFF0, 32'h0, 32'h21, h, prt, iwd, rd, nio, nack, ndone);
        check(h && nack == 1 && nio == 0 && ndone == 1, "R8 ack byte handshake",
              {28'h0, h, nio[0], nack[0], ndone[0]}, 32'hB);
        check(rd == 32'h0000_0021, "R8 ack byte vector", rd, 32'h0000_0021);
        do_access(1'b0, 2'd1, 1'b1, 32'hBFFF_FFF0, 32'h0, 32'h21, h, prt, iwd, rd, nio, nack, ndone);
        check(rd == 32'h0000_2100, "R8 ack half vector", rd, 32'h0000_2100);
        do_access(1'b0, 2'd2, 1'b0, 32'hBFFF_FFF0, 32'h0, 32'h21, h, prt, iwd, rd, nio, nack, ndone);
        check(rd == 32'h2100_0000, "R8 ack word vector", rd, 32'h2100_0000);

        // R9 local completions in the acknowledge region
        do_access(1'b0, 2'd0, 1'b0, 32'hBFFF_FFF2, 32'h0, 32'h77, h, prt, iwd, rd, nio, nack, ndone);
        check(h && nio == 0 && nack == 0 && ndone == 1 && rd == 32'h0, "R9 read other offset",
              rd, 32'h0);
        do_access(1'b1, 2'd2, 1'b0, 32'hBFFF_FFF0, 32'hDEAD_BEEF, 32'h77, h, prt, iwd, rd, nio, nack, ndone);
        check(h && nio == 0 && nack == 0 && ndone == 1, "R9 write ignored",
              {28'h0, h, nio[0], nack[0], ndone[0]}, 32'h9);

        // R9 completion timing: done in the cycle right after start
        @(negedge clk);
        cpu_start = 1'b1; cpu_write = 1'b0; cpu_size = 2'd0; cpu_addr = 32'hBFFF_FFF3;
        @(negedge clk);
        cpu_start = 1'b0;
        check(cpu_done && cpu_rdata == 32'h0, "R9 done next cycle", {31'h0, cpu_done}, 32'h1);
        @(negedge clk);
        check(!cpu_done, "R9 done one cycle", {31'h0, cpu_done}, 32'h0);

        // R7 map sampled at start, R10 busy start ignored
        @(negedge clk);
        cpu_start = 1'b1; cpu_write = 1'b1; cpu_size = 2'd1; map_mode = 1'b0;
        cpu_addr = 32'h8012_3456; cpu_wdata = 32'h0000_1357;
        @(negedge clk);
        cpu_start = 1'b0; map_mode = 1'b1;
        @(negedge clk);
        check(io_req && io_port == 20'h03456, "R7 port unchanged by map flip",
              {12'h0, io_port}, 32'h0000_3456);
        cpu_start = 1'b1; cpu_write = 1'b1; cpu_size = 2'd2;
        cpu_addr = 32'h8000_0008; cpu_wdata = 32'hFFFF_FFFF;
        #1 check(!cpu_hit, "R10 busy start not hit", {31'h0, cpu_hit}, 32'h0);
        @(negedge clk);
        cpu_start = 1'b0;
        check(io_req && io_port == 20'h03456 && io_wdata == 32'h0000_5713,
              "R10 pending request unchanged", io_wdata, 32'h0000_5713);
        io_ready = 1'b1;
        @(negedge clk);
        io_ready = 1'b0;
        check(cpu_done && !io_req, "R6 done after delayed ready", {31'h0, cpu_done}, 32'h1);
        @(negedge clk);
        check(!cpu_done && !io_req, "R10 no second access", {30'h0, cpu_done, io_req}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule